// File: doc/BRIEF.md
# Programmable Binary Threshold Neuron

This block is a threshold logic unit. It takes N one-bit inputs, a signed integer weight for each input and a signed threshold. It adds the weights of the inputs that are 1. It raises a one-bit firing output when that sum is at or above the threshold. Because the weights and the threshold are run-time values, one piece of hardware can act as AND, OR, a gate with negated literals, or any other function that a single hyperplane can separate.

The weights and the threshold are held in registers that reset to zero. They are loaded one at a time through a write port: a strobe, an index and a data word. Indices 0 to N-1 select a weight, index N selects the threshold, and higher indices are not used. The registers keep their values until they are written again. The firing output depends only on the current inputs and on the registered configuration, with no register between them.

Top module: `tlu_neuron`

## Requirements
- R1: After reset every weight and the threshold are zero, so `fire_o` is 1 for every input pattern.
- R2: A write with `wr_en_i` high and `wr_addr_i` = k < N stores `wr_data_i` into weight k. The new value first affects `fire_o` just after the clock edge that samples the strobe, and not before that edge.
- R3: A write to index N stores `wr_data_i` as the threshold. The threshold is a two's complement value, sign-extended for the comparison.
- R4: A write to any index above N changes no weight and no threshold.
- R5: The net value is the sum of the weights whose inputs are 1. `fire_o` is 1 exactly when net ≥ threshold, using a signed comparison, and 0 otherwise.
- R6: A weight of -1 acts as a negated literal. Net values below zero are compared as signed numbers. For example, weights (-1, 1) with threshold 1 give `fire_o` = !x0 & x1.
- R7: The accumulator never overflows. When every input is 1 and every weight is at the most negative or most positive value, the comparison is still exact.
- R8: Multiplying all weights and the threshold by the same positive factor leaves `fire_o` unchanged for every input pattern.
- R9: While `wr_en_i` is low, the weights and the threshold hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | $clog2(N+1) | Write index: 0..N-1 select a weight, N selects the threshold |
| wr_data_i | input | DATA_W | Signed weight or threshold value |
| x_i | input | N | Binary inputs; bit i is multiplied by weight i |
| fire_o | output | 1 | Goes to 1 when net ≥ threshold |

## Verification
The bench builds the block with N = 4 and DATA_W = 4. With these values every one of the 16 input patterns can be swept for each configuration. The 3-bit index also leaves indices 5 to 7 unused, so the ignored-write case can be tested. The 4-bit weight range of -8 to 7 means that the extreme weights make the sum reach -32 and +28. This tests the accumulator's guard bits and the signed comparison, while AND, OR, scaled AND and negated-literal gates are each checked against sums computed in the bench.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  // Accumulator width: data width plus enough guard bits for N terms.
  function automatic int acc_width(input int n, input int dw);
    return dw + $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tlu_cfg_regs.sv
module tlu_cfg_regs #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(N + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [N-1:0][DATA_W-1:0] weight_o,
  output logic [DATA_W-1:0]      thr_o
);
  logic [N-1:0][DATA_W-1:0] w_q;
  logic [DATA_W-1:0]        thr_q;
  logic                     thr_sel;

  assign thr_sel = wr_en_i && (wr_addr_i == ADDR_W'(N));

  for (genvar i = 0; i < N; i++) begin : g_w
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  w_q[i] <= '0;
      else if (sel) w_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      thr_q <= '0;
    else if (thr_sel) thr_q <= wr_data_i;
  end

  assign weight_o = w_q;
  assign thr_o    = thr_q;

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(w_q) && $stable(thr_q)));
  // R4
  bad_addr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > ADDR_W'(N)) |=> ($stable(w_q) && $stable(thr_q)));
  // R3
  thr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(N)) |=> (thr_q == $past(wr_data_i)));
  // R2
  weight_wr_keeps_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i < ADDR_W'(N)) |=> $stable(thr_q));
endmodule

// File: rtl/tlu_sum.sv
module tlu_sum #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  localparam int ACC_W = tlu_pkg::acc_width(N, DATA_W)
) (
  input  logic [N-1:0]             x_i,
  input  logic [N-1:0][DATA_W-1:0] weight_i,
  output logic signed [ACC_W-1:0]  net_o
);
  logic signed [ACC_W-1:0] term [N];

  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = x_i[i] ?
      {{(ACC_W-DATA_W){weight_i[i][DATA_W-1]}}, weight_i[i]} : '0;
  end

  always_comb begin
    net_o = '0;
    for (int i = 0; i < N; i++) net_o = net_o + term[i];
  end

  // R5: inactive inputs contribute nothing
  zero_in_zero_net_chk: assert property (@(x_i) (x_i == '0) |-> (net_o == '0));
endmodule

// File: rtl/tlu_cmp.sv
module tlu_cmp #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 11
) (
  input  logic signed [ACC_W-1:0] net_i,
  input  logic [DATA_W-1:0]       thr_i,
  output logic                    fire_o
);
  logic signed [ACC_W-1:0] thr_ext;
  assign thr_ext = {{(ACC_W-DATA_W){thr_i[DATA_W-1]}}, thr_i};
  assign fire_o  = (net_i >= thr_ext);
endmodule

// File: rtl/tlu_neuron.sv
module tlu_neuron #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(N + 1),
  localparam int ACC_W  = tlu_pkg::acc_width(N, DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N-1:0]      x_i,
  output logic              fire_o
);
  logic [N-1:0][DATA_W-1:0] weight;
  logic [DATA_W-1:0]        thr;
  logic signed [ACC_W-1:0]  net;

  tlu_cfg_regs #(.N(N), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .weight_o(weight), .thr_o(thr)
  );

  tlu_sum #(.N(N), .DATA_W(DATA_W)) u_sum (
    .x_i, .weight_i(weight), .net_o(net)
  );

  tlu_cmp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cmp (
    .net_i(net), .thr_i(thr), .fire_o
  );

  // R5: all-zero inputs fire exactly when threshold is not positive
  zero_input_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0) |-> (fire_o == ($signed(thr) <= 0)));
  // R7: net bounded by N times the largest weight magnitude
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net >= -ACC_W'(N << (DATA_W-1))) && (net <= ACC_W'(N * ((1 << (DATA_W-1)) - 1))));
endmodule

// File: tb/tlu_neuron_tb_top.sv
module tlu_neuron_tb_top;
  localparam int N = 4;
  localparam int DW = 4;
  localparam int AW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, fire;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N-1:0]  x = '0;
  int checks = 0, errors = 0;
  int wm [N];
  int thm;

  always #5 clk = ~clk;

  tlu_neuron #(.N(N), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .x_i(x), .fire_o(fire)
  );

  function automatic logic expect_fire(input logic [N-1:0] pat);
    int net = 0;
    for (int i = 0; i < N; i++) if (pat[i]) net += wm[i];
    return net >= thm;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s x=%b actual=%b expected=%b", req, x, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(addr); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
    if (addr < N) wm[addr] = d;
    else if (addr == N) thm = d;
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < (1 << N); p++) begin
      x = N'(p);
      #1;
      check(req, fire, expect_fire(N'(p)));
    end
  endtask

  task automatic load(input int w0, input int w1, input int w2, input int w3, input int t);
    wr(0, w0); wr(1, w1); wr(2, w2); wr(3, w3); wr(N, t);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) wm[i] = 0;
    thm = 0;
    #23 rst_n = 1;
    // R1: zero config fires on every pattern
    sweep("R1");
    // R2 R3 R5: two-input AND
    load(1, 1, 0, 0, 2);
    sweep("R5_and");
    // R5: two-input OR
    wr(N, 1);
    sweep("R5_or");
    // R8: AND scaled by 3
    load(3, 3, 0, 0, 6);
    sweep("R8");
    // R6: negated literal, !x0 & x1
    load(-1, 1, 0, 0, 1);
    sweep("R6");
    // R4: writes to unused indices leave config unchanged
    wr(5, 7); wr(6, -8); wr(7, 3);
    sweep("R4");
    // R7: extreme negative weights, net down to -32
    load(-8, -8, -8, -8, -8);
    sweep("R7_neg");
    // R7: extreme positive weights, net up to 28
    load(7, 7, 7, 7, 7);
    sweep("R7_pos");
    // R2: write timing; AND config, x=0011, threshold raised to 3
    load(1, 1, 0, 0, 2);
    @(negedge clk);
    x = 4'b0011;
    wr_en = 1; wr_addr = AW'(N); wr_data = DW'(3);
    #2 check("R2_before", fire, 1'b1);
    @(posedge clk); #1;
    check("R2_after", fire, 1'b0);
    @(negedge clk); wr_en = 0; thm = 3;
    // R9: idle cycles keep config
    repeat (5) @(negedge clk);
    sweep("R9");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule